// File: doc/BRIEF.md
# Burst Column Address Generator

This block steps through the column addresses of one SDRAM read or write burst. A new access is launched by pulsing `start` with the first column, a burst-length code and an ordering select. From the next clock on, the block presents one column per enabled clock on `colAddr`, qualified by `colValid`. The block raises `lastBeat` on the final column of a fixed-length burst. It has no memory array, data path or command decoder. A controller places it beside the command logic and uses its outputs to drive the column address pins and to decide when the next command may be issued.

Fixed bursts stay inside the aligned group of columns that holds the starting column. A full-page burst sweeps the whole row and keeps wrapping until something stops it. Either kind of burst ends early on `terminate`. A `start` in the middle of a burst abandons it and begins a new one at once. While `clkEn` is low the block is frozen, which models clock suspend.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is asserted, and on the first sample after it is released, `colValid` and `lastBeat` are 0 and `colAddr` is 0.
- R2: An enabled clock with `start` high makes `colValid` 1 on the following cycle, with `colAddr` equal to the `startCol` sampled at that edge.
- R3: `lenCode` is captured at `start`. Codes 0, 1, 2 and 3 select bursts of 1, 2, 4 and 8 beats. Code 7 selects full page. Codes 4, 5 and 6 act as a single beat. `lastBeat` is 1 exactly on the final beat of a fixed burst. The enabled clock that follows drops `colValid` unless `start` is high.
- R4: With `interleave` low, beat k of a fixed burst of length L has the upper column bits of `startCol` and the low bits ((startCol mod L) + k) mod L.
- R5: With `interleave` high, beat k of a fixed burst of length L has the upper column bits of `startCol` and the low bits (startCol mod L) XOR k.
- R6: A full-page burst gives (startCol + k) mod 512 on beat k. It wraps from 511 to 0, never raises `lastBeat`, ignores `interleave`, and runs until it is terminated or restarted.
- R7: An enabled clock with `terminate` high and `start` low ends the running burst: `colValid` is 0 on the following cycle.
- R8: `start` takes effect during a running burst and wins over a `terminate` on the same clock. The new burst begins at beat 0 of the newly supplied column, length and ordering.
- R9: While `clkEn` is low, `colValid`, `colAddr` and `lastBeat` keep their values, and `start` and `terminate` are ignored.
- R10: A `start` may be accepted on every enabled clock, so back-to-back single-beat accesses give a new column each cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| clkEn | input | 1 | Clock enable; low freezes the block |
| start | input | 1 | Launch a burst (new READ or WRITE) |
| startCol | input | 9 | First column of the burst |
| lenCode | input | 3 | Burst length code (see R3) |
| interleave | input | 1 | 1 = interleaved order, 0 = sequential |
| terminate | input | 1 | Cut the running burst short |
| colValid | output | 1 | A burst column is presented this cycle |
| colAddr | output | 9 | Column address of the current beat |
| lastBeat | output | 1 | Current beat is the last of a fixed burst |

## Verification
Several rules are checked on every cycle by properties that look only at the ports. These are the freeze under a low clock enable, the first-beat column after a start, the stop after a terminate or a final beat, `lastBeat` only appearing alongside `colValid`, and an unstopped burst staying valid. The exact column orderings can only be shown by the bench's scenarios, which compare every cycle against a behavioural model. These cover sequential and interleaved order, the length decoding including the reserved codes, the 511-to-0 wrap of a full page, and restarts mid-burst.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  // Strobes passed from control to datapath.
  typedef struct packed {
    logic load;     // capture a new starting column, clear beat index
    logic advance;  // step to the next beat
    logic ilv;      // ordering for the burst being loaded
  } bcg_strobes_t;
endpackage

// File: rtl/bcg_datapath.sv
module bcg_datapath
  import bcg_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  bcg_strobes_t     strb,
  input  logic [COL_W-1:0] startCol,
  input  logic [COL_W-1:0] loadMask,
  output logic [COL_W-1:0] beatIdx,
  output logic [COL_W-1:0] colAddr
);
  logic [COL_W-1:0] baseColQ;
  logic [COL_W-1:0] beatQ;
  logic [COL_W-1:0] maskQ;
  logic             ilvQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseColQ <= '0;
      beatQ    <= '0;
      maskQ    <= '0;
      ilvQ     <= 1'b0;
    end else if (strb.load) begin
      baseColQ <= startCol;
      beatQ    <= '0;
      maskQ    <= loadMask;
      ilvQ     <= strb.ilv;
    end else if (strb.advance) begin
      beatQ <= beatQ + 1'b1;
    end
  end

  // Low bits move inside the aligned group picked by the mask; upper bits stay.
  logic [COL_W-1:0] seqLow;
  logic [COL_W-1:0] ilvLow;
  logic [COL_W-1:0] lowBits;

  always_comb begin
    seqLow  = (baseColQ + beatQ) & maskQ;
    ilvLow  = (baseColQ ^ beatQ) & maskQ;
    lowBits = ilvQ ? ilvLow : seqLow;
    colAddr = (baseColQ & ~maskQ) | lowBits;
  end

  assign beatIdx = beatQ;
endmodule

// File: rtl/bcg_ctrl.sv
module bcg_ctrl
  import bcg_pkg::*;
#(
  parameter int COL_W         = 9,
  parameter int LEN_W         = 3,
  parameter int MAX_FIXED_LOG = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clkEn,
  input  logic             start,
  input  logic             terminate,
  input  logic [LEN_W-1:0] lenCode,
  input  logic             interleave,
  input  logic [COL_W-1:0] beatIdx,
  output bcg_strobes_t     strb,
  output logic [COL_W-1:0] loadMask,
  output logic             colValid,
  output logic             lastBeat
);
  localparam logic [LEN_W-1:0] FULL_CODE = {LEN_W{1'b1}};

  // Mask of the low column bits that cycle within a burst.
  function automatic logic [COL_W-1:0] maskOf(input logic [LEN_W-1:0] code);
    logic [COL_W:0] span;
    logic [COL_W:0] m;
    if (code == FULL_CODE) begin
      return {COL_W{1'b1}};
    end
    if (int'(code) > MAX_FIXED_LOG) begin
      return '0;
    end
    span = (COL_W+1)'(1) << code;
    m    = span - 1'b1;
    return m[COL_W-1:0];
  endfunction

  logic             activeQ;
  logic             fullQ;
  logic [COL_W-1:0] lastIdxQ;
  logic             finalBeat;
  logic             stopNow;

  assign finalBeat = activeQ && !fullQ && (beatIdx == lastIdxQ);
  assign stopNow   = clkEn && !start && activeQ && (terminate || finalBeat);

  always_comb begin
    strb.load    = clkEn && start;
    strb.advance = clkEn && !start && activeQ && !terminate && !finalBeat;
    strb.ilv     = interleave && (lenCode != FULL_CODE);
    loadMask     = maskOf(lenCode);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ  <= 1'b0;
      fullQ    <= 1'b0;
      lastIdxQ <= '0;
    end else if (strb.load) begin
      activeQ  <= 1'b1;
      fullQ    <= (lenCode == FULL_CODE);
      lastIdxQ <= loadMask;
    end else if (stopNow) begin
      activeQ <= 1'b0;
    end
  end

  assign colValid = activeQ;
  assign lastBeat = finalBeat;
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import bcg_pkg::*;
#(
  parameter int COL_W = 9,
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clkEn,
  input  logic             start,
  input  logic [COL_W-1:0] startCol,
  input  logic [LEN_W-1:0] lenCode,
  input  logic             interleave,
  input  logic             terminate,
  output logic             colValid,
  output logic [COL_W-1:0] colAddr,
  output logic             lastBeat
);
  bcg_strobes_t     strb;
  logic [COL_W-1:0] loadMask;
  logic [COL_W-1:0] beatIdx;

  bcg_ctrl #(.COL_W(COL_W), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .start(start),
    .terminate(terminate), .lenCode(lenCode), .interleave(interleave),
    .beatIdx(beatIdx), .strb(strb), .loadMask(loadMask),
    .colValid(colValid), .lastBeat(lastBeat)
  );

  bcg_datapath #(.COL_W(COL_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .startCol(startCol),
    .loadMask(loadMask), .beatIdx(beatIdx), .colAddr(colAddr)
  );
endmodule

// File: rtl/bcg_checker.sv
module bcg_checker #(
  parameter int COL_W = 9
) (
  input logic             clk,
  input logic             rstN,
  input logic             clkEn,
  input logic             start,
  input logic             terminate,
  input logic [COL_W-1:0] startCol,
  input logic             colValid,
  input logic [COL_W-1:0] colAddr,
  input logic             lastBeat
);
  assert_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && start) |=> (colValid && colAddr == $past(startCol)));

  assert_terminate_R7: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && !start && terminate) |=> !colValid);

  assert_final_stop_R3: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && !start && lastBeat) |=> !colValid);

  assert_last_qualified_R3: assert property (@(posedge clk) disable iff (!rstN)
    lastBeat |-> colValid);

  assert_freeze_R9: assert property (@(posedge clk) disable iff (!rstN)
    !clkEn |=> ($stable(colValid) && $stable(colAddr) && $stable(lastBeat)));

  assert_keeps_running_R6: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && !start && !terminate && colValid && !lastBeat) |=> colValid);
endmodule

bind burst_col_gen bcg_checker #(.COL_W(COL_W)) u_chk (
  .clk(clk), .rstN(rstN), .clkEn(clkEn), .start(start),
  .terminate(terminate), .startCol(startCol), .colValid(colValid),
  .colAddr(colAddr), .lastBeat(lastBeat)
);

// File: tb/burst_col_gen_tb.sv
`timescale 1ns/1ps
module burst_col_gen_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       clkEn = 1'b0;
  logic       start = 1'b0;
  logic [8:0] startCol = '0;
  logic [2:0] lenCode = '0;
  logic       interleave = 1'b0;
  logic       terminate = 1'b0;
  logic       colValid;
  logic [8:0] colAddr;
  logic       lastBeat;

  int checks = 0;
  int failures = 0;

  // behavioural model state
  int mActive = 0;
  int mCol = 0;
  int mBeat = 0;
  int mLen = 1;   // 0 means full page
  int mIlv = 0;

  always #10 clk = ~clk;

  burst_col_gen u_dut (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .start(start), .startCol(startCol),
    .lenCode(lenCode), .interleave(interleave), .terminate(terminate),
    .colValid(colValid), .colAddr(colAddr), .lastBeat(lastBeat)
  );

  function automatic int lenOf(input int code);
    case (code)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 8;
      7: return 0;
      default: return 1;
    endcase
  endfunction

  function automatic int expAddr();
    int low;
    int base;
    if (mLen == 0) return (mCol + mBeat) % 512;
    low  = mCol % mLen;
    base = mCol - low;
    if (mIlv != 0) return base + (low ^ mBeat);
    return base + ((low + mBeat) % mLen);
  endfunction

  function automatic int expLast();
    return (mActive != 0 && mLen != 0 && mBeat == mLen - 1) ? 1 : 0;
  endfunction

  task automatic compare(input string tag);
    int ea;
    int el;
    ea = expAddr();
    el = expLast();
    checks++;
    if (colValid !== (mActive != 0) || lastBeat !== el[0] ||
        (mActive != 0 && colAddr !== ea[8:0])) begin
      failures++;
      $display("FAIL %s: valid=%0b addr=%0d last=%0b expected valid=%0d addr=%0d last=%0d",
               tag, colValid, colAddr, lastBeat, mActive, ea, el);
    end
  endtask

  task automatic step(input logic ce, input logic st, input int col, input int len,
                      input logic il, input logic tm, input string tag);
    int lastNow;
    clkEn = ce; start = st; startCol = col[8:0]; lenCode = len[2:0];
    interleave = il; terminate = tm;
    @(posedge clk);
    lastNow = expLast();
    if (ce) begin
      if (st) begin
        mActive = 1; mCol = col; mBeat = 0; mLen = lenOf(len);
        mIlv = (mLen == 0) ? 0 : int'(il);
      end else if (mActive != 0) begin
        if (tm || lastNow != 0) mActive = 0;
        else mBeat = (mBeat + 1) % 512;
      end
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 0, 0, 1'b0, 1'b0, tag);
  endtask

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1 reset state
    @(negedge clk);
    checks++;
    if (colValid !== 1'b0 || lastBeat !== 1'b0 || colAddr !== 9'd0) begin
      failures++;
      $display("FAIL R1: valid=%0b addr=%0d last=%0b expected 0 0 0", colValid, colAddr, lastBeat);
    end
    rstN = 1'b1;
    @(negedge clk);
    compare("R1 after release");

    // R4 sequential length 8 from 13: 13,14,15,8,9,10,11,12
    step(1, 1, 13, 3, 0, 0, "R2 load seq8");
    idle(9, "R4 seq8");
    // R5 interleaved length 8 from 13: 13,12,15,14,9,8,11,10
    step(1, 1, 13, 3, 1, 0, "R2 load ilv8");
    idle(9, "R5 ilv8");
    // R4 length 4 from 6, R5 length 2 from 3
    step(1, 1, 6, 2, 0, 0, "R3 len4");
    idle(5, "R4 seq4");
    step(1, 1, 3, 1, 1, 0, "R3 len2");
    idle(3, "R5 ilv2");
    // R3 single beat and reserved codes
    step(1, 1, 100, 0, 0, 0, "R3 len1");
    idle(2, "R3 len1 end");
    step(1, 1, 77, 5, 1, 0, "R3 reserved code");
    idle(2, "R3 reserved end");
    // R6 full page from 509 with interleave requested, wraps past 511
    step(1, 1, 509, 7, 1, 0, "R6 full load");
    idle(520, "R6 full page run");
    step(1, 0, 0, 0, 0, 1, "R7 terminate full page");
    idle(2, "R7 after terminate");
    // R7 terminate a fixed burst mid-way
    step(1, 1, 40, 3, 0, 0, "R7 load");
    idle(2, "R7 running");
    step(1, 0, 0, 0, 0, 1, "R7 terminate fixed");
    idle(2, "R7 stays idle");
    // R8 restart mid-burst, with terminate on the same clock
    step(1, 1, 200, 3, 0, 0, "R8 first burst");
    idle(3, "R8 first running");
    step(1, 1, 301, 2, 1, 1, "R8 restart wins over terminate");
    idle(5, "R8 second burst");
    // R9 freeze mid-burst; start and terminate ignored
    step(1, 1, 50, 3, 1, 0, "R9 load");
    idle(2, "R9 running");
    step(0, 1, 400, 0, 0, 0, "R9 frozen start ignored");
    step(0, 0, 0, 0, 0, 1, "R9 frozen terminate ignored");
    step(0, 0, 0, 0, 0, 0, "R9 frozen");
    idle(7, "R9 resume");
    // R10 back-to-back single beats
    for (int i = 0; i < 6; i++) step(1, 1, 10 + 37 * i, 0, 0, 0, "R10 back to back");
    idle(2, "R10 end");
    // R10 back-to-back restarts of longer bursts
    for (int i = 0; i < 4; i++) step(1, 1, 500 + i, 2, i % 2, 0, "R10 restart each cycle");
    idle(5, "R10 final burst");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule